// File: doc/BRIEF.md
# Four-Domain Programmable Clock Divider Controller

This block sits behind a fixed ×8 frequency multiplier and turns its single fast base clock into four clock-enable strobes, one each for the core, bus, peripheral and timer domains. Software selects each domain's division ratio through a 3-bit code in a 12-bit ratio register. The register is read back as the setting that is currently in force.

A write is first screened. Every code must be a defined ratio, and the four ratios must keep the required frequency ordering between domains. A write that fails either test changes nothing and raises a sticky error flag. A write that passes is held as pending, and the block reports busy. The new ratios are applied only after a staged switchover delay. The delay waits for the next common alignment point of all divider phases. It then counts bus-domain strobes and then peripheral-domain strobes under the old ratios, and waits for one more alignment point. All four strobes change ratio on that same cycle.

Top module: `clkdiv_ctrl`

## Requirements
- R1: After reset, `rd_cfg` reads 12'h6DB (every field holds code 3'b011, divide-by-4), and `busy` and `err` are low.
- R2: Field codes map as 3'b000 = ÷1, 3'b001 = ÷2, 3'b011 = ÷4 and 3'b101 = ÷8. A domain strobe set to ÷N is high for exactly one base cycle in every N. With ÷1 the strobe is high on every cycle.
- R3: Counting base cycles from reset release as t = 0, 1, 2, …, a strobe set to ÷N is high exactly when t mod N = 0. In particular, all four strobes are high together whenever t mod 8 = 0.
- R4: With the field layout core = bits [2:0], bus = [5:3], peripheral = [8:6] and timer = [11:9], a write is accepted only under these conditions. The bus and peripheral ratios are equal. The bus ratio is ÷2, ÷4 or ÷8. The core ratio is no larger than the bus ratio. The timer ratio lies between the core ratio and the peripheral ratio, both ends included. Any other write leaves `rd_cfg` and the strobes unchanged.
- R5: A write that holds any code other than the four defined codes is rejected, and the applied setting never holds an undefined code.
- R6: A rejected write made while idle sets `err` from the next cycle on. `err_clr` clears it, but a rejection in the same cycle as `err_clr` wins.
- R7: `busy` rises on the cycle after an accepted write and stays high until the apply cycle. A write seen while `busy` is high is dropped without any check, so it neither changes the setting nor sets `err`.
- R8: Take write cycle w. Let A be the first cycle after w with t mod 8 = 0. Let B be the 11th cycle after A in which the old bus strobe is high, P the 7th cycle after B in which the old peripheral strobe is high, and S the first cycle after P with t mod 8 = 0. Then `busy` is high from w+1 through S and low at S+1.
- R9: From cycle S+1, all four strobes follow the new ratios, and `rd_cfg` shows the new value on that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock from the ×8 multiplier |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Ratio register write strobe |
| wr_data | input | 12 | Requested ratio fields (timer, peripheral, bus, core from MSB down) |
| err_clr | input | 1 | Clears the sticky error flag |
| rd_cfg | output | 12 | Ratio fields currently applied |
| busy | output | 1 | A switchover is pending |
| err | output | 1 | Sticky flag for a rejected write |
| en_core | output | 1 | Core domain clock enable |
| en_bus | output | 1 | Bus domain clock enable |
| en_per | output | 1 | Peripheral domain clock enable |
| en_tmr | output | 1 | Timer domain clock enable |

## Verification
The bench builds the block with its default parameters: a 3-bit base phase counter, an 11-strobe bus stage and a 7-strobe peripheral stage. The 3-bit counter keeps every alignment wait at 8 cycles or fewer, so one switchover takes at most about 160 cycles. A few thousand cycles of random writes therefore cover many complete switchovers from every legal starting ratio, including the slowest ÷8 bus case and the ÷1 core case. The same short wait lets the bench land writes on the last busy cycle and the first idle cycle, and issue error clears that collide with rejections.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   localparam int CODE_W  = 3;
   localparam int SHIFT_W = 2;
   localparam int NUM_DOM = 4;

   // domain slot order inside the ratio register, LSB first
   localparam int DOM_CORE = 0;
   localparam int DOM_BUS  = 1;
   localparam int DOM_PER  = 2;
   localparam int DOM_TMR  = 3;

   typedef struct packed {
      logic [CODE_W-1:0] tmr;
      logic [CODE_W-1:0] per;
      logic [CODE_W-1:0] bus;
      logic [CODE_W-1:0] core;
   } ratio_cfg_t;

   typedef struct packed {
      logic               ok;
      logic [SHIFT_W-1:0] sh;
   } ratio_dec_t;

   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_ALIGN = 3'd1,
      SQ_BUS   = 3'd2,
      SQ_PER   = 3'd3,
      SQ_SYNC  = 3'd4
   } seq_state_e;

   localparam logic [NUM_DOM*CODE_W-1:0] CFG_RESET = 12'h6DB;

   // code to log2 of the division ratio
   function automatic ratio_dec_t decode_code(input logic [CODE_W-1:0] c);
      ratio_dec_t r;
      r.ok = 1'b1;
      r.sh = '0;
      case (c)
         3'b000:  r.sh = 2'd0;
         3'b001:  r.sh = 2'd1;
         3'b011:  r.sh = 2'd2;
         3'b101:  r.sh = 2'd3;
         default: r.ok = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/clkdiv_rules.sv
module clkdiv_rules
   import clkdiv_pkg::*;
(
   input  ratio_cfg_t req,
   output logic       legal
);

   ratio_dec_t d_core, d_bus, d_per, d_tmr;

   always_comb begin
      d_core = decode_code(req.core);
      d_bus  = decode_code(req.bus);
      d_per  = decode_code(req.per);
      d_tmr  = decode_code(req.tmr);
   end

   logic codes_ok, bus_eq_per, bus_not_one, core_fastest, tmr_between;

   always_comb begin
      codes_ok     = d_core.ok & d_bus.ok & d_per.ok & d_tmr.ok;
      bus_eq_per   = (d_bus.sh == d_per.sh);
      bus_not_one  = (d_bus.sh != '0);
      core_fastest = (d_core.sh <= d_bus.sh);
      tmr_between  = (d_core.sh <= d_tmr.sh) && (d_tmr.sh <= d_per.sh);
      legal = codes_ok & bus_eq_per & bus_not_one & core_fastest & tmr_between;
   end

endmodule

// File: rtl/clkdiv_engine.sv
module clkdiv_engine
   import clkdiv_pkg::*;
#(
   parameter int BASE_W = 3
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_DOM*SHIFT_W-1:0] shifts,
   output logic [NUM_DOM-1:0]         en,
   output logic                       align
);

   logic [BASE_W-1:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) base_q <= '0;
      else        base_q <= base_q + 1'b1;
   end

   assign align = (base_q == '0);

   for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
      logic [SHIFT_W-1:0] sh;
      logic [BASE_W-1:0]  mask;
      assign sh    = shifts[g*SHIFT_W +: SHIFT_W];
      assign mask  = (BASE_W'(1) << sh) - BASE_W'(1);
      assign en[g] = ((base_q & mask) == '0);
   end

endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
   import clkdiv_pkg::*;
#(
   parameter int BUS_WAIT = 11,
   parameter int PER_WAIT = 7
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic align,
   input  logic en_bus,
   input  logic en_per,
   output logic busy,
   output logic apply
);

   localparam int MAXW = (BUS_WAIT > PER_WAIT) ? BUS_WAIT : PER_WAIT;
   localparam int CW   = $clog2(MAXW + 1);

   seq_state_e    st_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SQ_IDLE;
         cnt_q <= '0;
      end else begin
         case (st_q)
            SQ_IDLE:  if (start) st_q <= SQ_ALIGN;
            SQ_ALIGN: if (align) begin
                         st_q  <= SQ_BUS;
                         cnt_q <= '0;
                      end
            SQ_BUS:   if (en_bus) begin
                         if (cnt_q == CW'(BUS_WAIT - 1)) begin
                            st_q  <= SQ_PER;
                            cnt_q <= '0;
                         end else begin
                            cnt_q <= cnt_q + 1'b1;
                         end
                      end
            SQ_PER:   if (en_per) begin
                         if (cnt_q == CW'(PER_WAIT - 1)) begin
                            st_q  <= SQ_SYNC;
                            cnt_q <= '0;
                         end else begin
                            cnt_q <= cnt_q + 1'b1;
                         end
                      end
            SQ_SYNC:  if (align) st_q <= SQ_IDLE;
            default:  st_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy  = (st_q != SQ_IDLE);
   assign apply = (st_q == SQ_SYNC) && align;

   // R2
   bus_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_bus && !apply) |=> !en_bus);

   // R8
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(apply));

endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
   import clkdiv_pkg::*;
#(
   parameter int BASE_W   = 3,
   parameter int BUS_WAIT = 11,
   parameter int PER_WAIT = 7
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [11:0] wr_data,
   input  logic        err_clr,
   output logic [11:0] rd_cfg,
   output logic        busy,
   output logic        err,
   output logic        en_core,
   output logic        en_bus,
   output logic        en_per,
   output logic        en_tmr
);

   localparam int CFG_W = NUM_DOM * CODE_W;

   if (BASE_W < 3) begin : g_bad_base
      $error("BASE_W must cover the slowest ratio of 8");
   end
   if (BUS_WAIT < 1 || PER_WAIT < 1) begin : g_bad_wait
      $error("switchover stage lengths must be at least 1");
   end

   logic [CFG_W-1:0] cfg_q, pend_q;
   logic             err_q;
   logic             legal, start, apply, align;
   logic [NUM_DOM-1:0]         en_v, act_ok;
   logic [NUM_DOM*SHIFT_W-1:0] act_sh;

   clkdiv_rules u_rules (
      .req   (ratio_cfg_t'(wr_data)),
      .legal (legal)
   );

   assign start = wr_en && !busy && legal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= CFG_RESET;
         pend_q <= CFG_RESET;
         err_q  <= 1'b0;
      end else begin
         if (start) pend_q <= wr_data;
         if (apply) cfg_q  <= pend_q;
         if (wr_en && !busy && !legal) err_q <= 1'b1;
         else if (err_clr)             err_q <= 1'b0;
      end
   end

   for (genvar g = 0; g < NUM_DOM; g++) begin : g_act
      ratio_dec_t dc;
      assign dc = decode_code(cfg_q[g*CODE_W +: CODE_W]);
      assign act_sh[g*SHIFT_W +: SHIFT_W] = dc.sh;
      assign act_ok[g] = dc.ok;
   end

   clkdiv_seq #(.BUS_WAIT(BUS_WAIT), .PER_WAIT(PER_WAIT)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .align  (align),
      .en_bus (en_v[DOM_BUS]),
      .en_per (en_v[DOM_PER]),
      .busy   (busy),
      .apply  (apply)
   );

   clkdiv_engine #(.BASE_W(BASE_W)) u_eng (
      .clk    (clk),
      .rst_n  (rst_n),
      .shifts (act_sh),
      .en     (en_v),
      .align  (align)
   );

   assign rd_cfg  = cfg_q;
   assign err     = err_q;
   assign en_core = en_v[DOM_CORE];
   assign en_bus  = en_v[DOM_BUS];
   assign en_per  = en_v[DOM_PER];
   assign en_tmr  = en_v[DOM_TMR];

   // R7
   wr_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en && !apply) |=> $stable(rd_cfg));

   // R6
   bad_wr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy && !legal) |=> (err && $stable(rd_cfg)));

   // R3
   apply_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      apply |-> (en_core && en_bus && en_per && en_tmr));

   // R5
   cfg_code_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&act_ok));

endmodule

// File: tb/sim_clkdiv_ctrl.sv
`timescale 1ns/1ps
module sim_clkdiv_ctrl;

   localparam int BASE_MOD = 8;
   localparam int BUS_N    = 11;
   localparam int PER_N    = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_data = '0;
   logic        err_clr = 1'b0;
   logic [11:0] rd_cfg;
   logic        busy, err, en_core, en_bus, en_per, en_tmr;

   always #2.5 clk = ~clk;

   clkdiv_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .err_clr(err_clr), .rd_cfg(rd_cfg), .busy(busy), .err(err),
      .en_core(en_core), .en_bus(en_bus), .en_per(en_per), .en_tmr(en_tmr)
   );

   int n_run = 0, n_fail = 0;
   int t = 0;
   bit done = 0;
   logic [11:0] cur_cfg = 12'h6DB, pend_cfg = '0;
   bit pend = 0, err_m = 0;
   int t_w = 0, t_s = 0;

   function automatic int sh_of(input logic [2:0] c);
      case (c)
         3'b000: return 0;
         3'b001: return 1;
         3'b011: return 2;
         3'b101: return 3;
         default: return -1;
      endcase
   endfunction

   function automatic logic [2:0] code_of(input int s);
      case (s)
         0: return 3'b000;
         1: return 3'b001;
         2: return 3'b011;
         default: return 3'b101;
      endcase
   endfunction

   function automatic logic [11:0] mk(input int c, input int b, input int p, input int m);
      return {code_of(m), code_of(p), code_of(b), code_of(c)};
   endfunction

   function automatic bit legal_f(input logic [11:0] d);
      int c = sh_of(d[2:0]);
      int b = sh_of(d[5:3]);
      int p = sh_of(d[8:6]);
      int m = sh_of(d[11:9]);
      if (c < 0 || b < 0 || p < 0 || m < 0) return 0;
      return (b == p) && (b >= 1) && (c <= b) && (c <= m) && (m <= p);
   endfunction

   // R8 expected apply cycle
   function automatic int predict(input int tw, input int bsh, input int psh);
      int tt = tw + 1;
      int n = 0;
      while (tt % BASE_MOD != 0) tt++;
      tt++;
      while (n < BUS_N) begin
         if (tt % (1 << bsh) == 0) n++;
         if (n < BUS_N) tt++;
      end
      tt++;
      n = 0;
      while (n < PER_N) begin
         if (tt % (1 << psh) == 0) n++;
         if (n < PER_N) tt++;
      end
      tt++;
      while (tt % BASE_MOD != 0) tt++;
      return tt;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at t=%0d: actual %0h expected %0h", req, t, act, exp);
      end
   endtask

   task automatic cyc(input bit w, input logic [11:0] d, input bit c);
      bit exp_busy;
      logic [3:0] exp_en;
      bit rej;
      if (pend && t == t_s + 1) begin
         cur_cfg = pend_cfg;
         pend = 0;
      end
      exp_busy = pend && (t > t_w);
      for (int k = 0; k < 4; k++)
         exp_en[k] = ((t % (1 << sh_of(cur_cfg[k*3 +: 3]))) == 0);
      // R2 R3 strobe pattern and alignment
      check({en_tmr, en_per, en_bus, en_core} == exp_en, "R2/R3 enables",
            int'({en_tmr, en_per, en_bus, en_core}), int'(exp_en));
      // R7 R8 busy window
      check(busy == exp_busy, "R7/R8 busy", int'(busy), int'(exp_busy));
      // R6 sticky error
      check(err == err_m, "R6 err", int'(err), int'(err_m));
      // R4 R5 R9 applied setting
      check(rd_cfg == cur_cfg, "R9 rd_cfg", int'(rd_cfg), int'(cur_cfg));
      wr_en   = w;
      wr_data = d;
      err_clr = c;
      rej = 0;
      if (w && !exp_busy) begin
         if (legal_f(d)) begin
            pend = 1;
            pend_cfg = d;
            t_w = t;
            t_s = predict(t, sh_of(cur_cfg[5:3]), sh_of(cur_cfg[8:6]));
         end else begin
            rej = 1;
         end
      end
      if (rej) err_m = 1;
      else if (c) err_m = 0;
      @(posedge clk);
      t++;
      @(negedge clk);
      wr_en = 0;
      err_clr = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, '0, 0);
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t = 0;
      // R1 reset state
      check(rd_cfg == 12'h6DB, "R1 reset cfg", int'(rd_cfg), 12'h6DB);
      check(!busy && !err, "R1 reset flags", int'({busy, err}), 0);
      idle(10);
      // R5 reserved code in core field
      cyc(1, 12'h6DA, 0);
      idle(3);
      cyc(0, '0, 1);
      // R4 bus differs from peripheral
      cyc(1, mk(1, 1, 2, 2), 0);
      idle(2);
      // R4 bus at divide-by-1
      cyc(1, mk(0, 0, 0, 0), 0);
      cyc(0, '0, 1);
      // R4 core slower than bus
      cyc(1, mk(3, 2, 2, 3), 0);
      cyc(0, '0, 1);
      // R4 timer slower than peripheral
      cyc(1, mk(1, 2, 2, 3), 0);
      // R6 rejection collides with clear: error stays set
      cyc(1, mk(2, 1, 2, 2), 1);
      idle(2);
      cyc(0, '0, 1);
      idle(2);
      // R2 core at divide-by-1, bus and peripheral at divide-by-8
      cyc(1, mk(0, 3, 3, 2), 0);
      // R7 writes while busy are dropped, even illegal ones
      cyc(1, mk(1, 1, 1, 1), 0);
      cyc(1, 12'hFFF, 0);
      idle(250);
      // R8 R9 all at divide-by-2, then a write on the first idle cycle
      cyc(1, mk(1, 1, 1, 1), 0);
      while (busy) cyc(0, '0, 0);
      cyc(1, mk(2, 3, 3, 3), 0);
      idle(200);
      // random phase
      for (int i = 0; i < 4000; i++) begin
         bit w = ($urandom % 8) == 0;
         bit c = ($urandom % 16) == 0;
         logic [11:0] d;
         if (($urandom % 4) != 0) begin
            int p = 1 + int'($urandom % 3);
            int cc = int'($urandom % (p + 1));
            int m = cc + int'($urandom % (p - cc + 1));
            d = mk(cc, p, p, m);
         end else begin
            d = 12'($urandom);
         end
         cyc(w, d, c);
      end
      idle(200);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule